// File: doc/BRIEF.md
# Text-Mode VRAM Slot Sequencer

This block decides what happens in every video-memory slot of one scan line for a tile display engine in its 40-column text mode. A slot counter moves forward one step for each slot-enable pulse. Each slot it is in gets one of three kinds of access: a pattern-name read, a pattern-value read, or a window handed to the host processor. In the same slot the block tells the pixel pipeline whether to draw border, draw active picture, or draw nothing.

For name reads it computes the name-table address. In text mode the row term is a multiple of forty. When the text-mode bit is clear, the address follows the graphics-mode layout instead. The name byte returned in a name slot is kept for the pattern-value read that follows in the same group. That later read's address is formed outside this block. Near the end of the line, at a slot set by a parameter, the block gives a one-slot strobe so that the external line counter can advance.

Top module: `text_slot_seq`

## Requirements
- R1: After reset the slot counter is 0, `acc_kind` is 3 (external), `pix_kind` is 1 (border), `name_q` is 0 and `line_adv` is 0.
- R2: Slots 0 to 3 each grant an external access (`acc_kind` 3).
- R3: Slots 4 to 123 form forty groups of three slots. The first slot of each group is a name read (`acc_kind` 1), the second is external (3) and the third is a pattern-value read (2).
- R4: `pix_kind` is 1 (border) for slots below 8, 2 (active) for slots 8 to 126, 1 for slots 127 to 138, and 0 (no pixel) for every other slot.
- R5: Slots 124 to 147, and every slot from 233 upward, grant an external access.
- R6: On a slot-enable pulse the counter goes from 147 to 233, from LAST_SLOT to 0, and from any other slot to the next one.
- R7: With `text_mode` high, a name read's address is computed in two steps. First, (`name_base`<<10 & 0x3C00) is OR'ed with (`vline`/8)×40. Then (slot−4)/3 is added. The result is 14 bits.
- R8: With `text_mode` low, a name read's address is (`name_base`<<10 & 0x3C00) | (`vline`<<2 & 0x03E0) | (slot>>2).
- R9: The `name_data` value present on the enable pulse of a name slot is loaded into `name_q`. It is still there in the pattern-value slot of the same group.
- R10: `line_adv` is high exactly when `slot_en` is high and the slot is ADV_SLOT.
- R11: While `slot_en` is low, the slot counter, `acc_kind`, `pix_kind` and `name_q` do not change, whatever `name_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One pulse per memory slot |
| text_mode | input | 1 | High selects 40-column text addressing |
| name_base | input | 4 | Name-table base field |
| vline | input | LINE_W | Current line number |
| name_data | input | 8 | Byte returned by the name read |
| slot | output | SLOT_W | Current slot number |
| acc_kind | output | 2 | 0 none, 1 name, 2 pattern, 3 external |
| pix_kind | output | 2 | 0 none, 1 border, 2 active |
| vram_addr | output | 14 | Name-table address, meaningful in name slots |
| name_q | output | 8 | Latched name byte |
| line_adv | output | 1 | Line-advance strobe |

## Verification
The line-advance strobe and an external access grant fall in the same slot, ADV_SLOT. The bench walks whole lines and checks, at the ADV_SLOT pulse, both the strobe and the external access kind, and it checks that no other slot raises the strobe. In slots 8 to 123, an active-pixel flag also coincides with each name or pattern read. These slots are judged by checking the pixel kind, the access kind and the address of every slot against models computed in the bench from the slot number.

// File: rtl/text_slot_seq.sv
module text_slot_seq #(
  parameter int LAST_SLOT = 255,
  parameter int ADV_SLOT  = 250,
  parameter int LINE_W    = 8,
  localparam int SLOT_W   = $clog2(LAST_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              text_mode,
  input  logic [3:0]        name_base,
  input  logic [LINE_W-1:0] vline,
  input  logic [7:0]        name_data,
  output logic [SLOT_W-1:0] slot,
  output logic [1:0]        acc_kind,
  output logic [1:0]        pix_kind,
  output logic [13:0]       vram_addr,
  output logic [7:0]        name_q,
  output logic              line_adv
);
  localparam logic [SLOT_W-1:0] S_GRP0 = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] S_GRPN = SLOT_W'(123);
  localparam logic [SLOT_W-1:0] S_ACT0 = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] S_ACTN = SLOT_W'(126);
  localparam logic [SLOT_W-1:0] S_BRDN = SLOT_W'(138);
  localparam logic [SLOT_W-1:0] S_JMP  = SLOT_W'(147);
  localparam logic [SLOT_W-1:0] S_LAND = SLOT_W'(233);
  localparam logic [SLOT_W-1:0] S_LAST = SLOT_W'(LAST_SLOT);
  localparam logic [SLOT_W-1:0] S_ADV  = SLOT_W'(ADV_SLOT);

  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic [1:0] ph_q;
  logic [5:0] col_q;
  logic in_grp;

  assign in_grp  = (slot_q >= S_GRP0) && (slot_q <= S_GRPN);
  assign slot_nx = (slot_q == S_JMP)  ? S_LAND :
                   (slot_q == S_LAST) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      ph_q   <= '0;
      col_q  <= '0;
      name_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_nx;
      if (slot_q == S_GRP0 - 1'b1) begin
        ph_q  <= '0;
        col_q <= '0;
      end else if (in_grp) begin
        if (ph_q == 2'd2) begin
          ph_q  <= '0;
          col_q <= col_q + 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
      if (in_grp && ph_q == 2'd0) name_q <= name_data;
    end
  end

  always_comb begin
    if (!in_grp)            acc_kind = 2'd3;
    else if (ph_q == 2'd0)  acc_kind = 2'd1;
    else if (ph_q == 2'd1)  acc_kind = 2'd3;
    else                    acc_kind = 2'd2;
  end

  always_comb begin
    if (slot_q < S_ACT0)        pix_kind = 2'd1;
    else if (slot_q <= S_ACTN)  pix_kind = 2'd2;
    else if (slot_q <= S_BRDN)  pix_kind = 2'd1;
    else                        pix_kind = 2'd0;
  end

  logic [13:0] base_f, row40, text_addr, gfx_addr;
  assign base_f    = {name_base, 10'b0};
  assign row40     = 14'(vline >> 3) * 14'd40;
  assign text_addr = (base_f | row40) + 14'(col_q);
  assign gfx_addr  = base_f | ((14'(vline) << 2) & 14'h03E0) | 14'(slot_q >> 2);
  assign vram_addr = text_mode ? text_addr : gfx_addr;

  assign slot     = slot_q;
  assign line_adv = slot_en && (slot_q == S_ADV);
endmodule

module text_slot_seq_chk #(
  parameter int SLOT_W   = 8,
  parameter int LAST_SLOT = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_en,
  input logic [SLOT_W-1:0] slot,
  input logic [1:0]        acc_kind,
  input logic [7:0]        name_data,
  input logic [7:0]        name_q,
  input logic              line_adv
);
  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot == SLOT_W'(147)) |=> (slot == SLOT_W'(233)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot == SLOT_W'(LAST_SLOT)) |=> (slot == '0));
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && acc_kind == 2'd1) |=> (acc_kind == 2'd3));
  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && acc_kind == 2'd1) |=> (name_q == $past(name_data)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> ($stable(slot) && $stable(name_q)));
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv |-> (acc_kind == 2'd3));
endmodule

bind text_slot_seq text_slot_seq_chk #(.SLOT_W(SLOT_W), .LAST_SLOT(LAST_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot(slot), .acc_kind(acc_kind),
  .name_data(name_data), .name_q(name_q), .line_adv(line_adv));

// File: tb/sim_text_slot_seq.sv
`timescale 1ns/1ps
module sim_text_slot_seq;
  localparam int LAST = 255;
  localparam int ADV  = 250;

  logic clk = 0, rst_n = 0, slot_en = 0, text_mode = 1;
  logic [3:0] name_base = 0;
  logic [7:0] vline = 0, name_data = 0;
  logic [7:0] slot, name_q;
  logic [1:0] acc_kind, pix_kind;
  logic [13:0] vram_addr;
  logic line_adv;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  text_slot_seq #(.LAST_SLOT(LAST), .ADV_SLOT(ADV), .LINE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .text_mode(text_mode),
    .name_base(name_base), .vline(vline), .name_data(name_data), .slot(slot),
    .acc_kind(acc_kind), .pix_kind(pix_kind), .vram_addr(vram_addr),
    .name_q(name_q), .line_adv(line_adv));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_acc(int s);
    if (s < 4) return 3;
    if (s <= 123) return ((s-4)%3 == 0) ? 1 : ((s-4)%3 == 1) ? 3 : 2;
    return 3;
  endfunction

  function automatic int exp_pix(int s);
    if (s < 8) return 1;
    if (s <= 126) return 2;
    if (s <= 138) return 1;
    return 0;
  endfunction

  function automatic int nxt(int s);
    if (s == 147) return 233;
    if (s == LAST) return 0;
    return s + 1;
  endfunction

  function automatic int exp_addr(int s);
    int b = (int'(name_base) << 10) & 32'h3C00;
    if (text_mode) return ((b | ((int'(vline) / 8) * 40)) + (s-4)/3) & 32'h3FFF;
    return b | ((int'(vline) << 2) & 32'h03E0) | (s >> 2);
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(slot == 0, "R1 slot", slot, 0);
    chk(acc_kind == 3, "R1 acc", acc_kind, 3);
    chk(pix_kind == 1, "R1 pix", pix_kind, 1);
    chk(name_q == 0, "R1 name_q", name_q, 0);
    chk(line_adv == 0, "R1 line_adv", line_adv, 0);
  endtask

  task automatic t_line(input bit tm, input logic [3:0] base, input logic [7:0] vl);
    int s = 0;
    text_mode = tm; name_base = base; vline = vl;
    do begin
      name_data = 8'(s) ^ 8'h5A;
      chk(slot == 8'(s), "R6 slot sequence", slot, s);
      chk(acc_kind == 2'(exp_acc(s)), (s < 4) ? "R2 access" : (s <= 123) ? "R3 access" : "R5 access",
          acc_kind, exp_acc(s));
      chk(pix_kind == 2'(exp_pix(s)), "R4 pixel kind", pix_kind, exp_pix(s));
      if (exp_acc(s) == 1)
        chk(vram_addr == 14'(exp_addr(s)), tm ? "R7 text addr" : "R8 gfx addr", vram_addr, exp_addr(s));
      if (exp_acc(s) == 2)
        chk(name_q == (8'(s-2) ^ 8'h5A), "R9 name latch", name_q, (s-2) ^ 'h5A);
      slot_en = 1;
      #1;
      chk(line_adv == (s == ADV), "R10 line strobe", line_adv, s == ADV);
      if (s == ADV) chk(acc_kind == 3, "R10 strobe with external", acc_kind, 3);
      @(posedge clk); @(negedge clk);
      slot_en = 0;
      s = nxt(s);
    end while (s != 0);
    chk(slot == 0, "R6 wrap", slot, 0);
  endtask

  task automatic t_hold();
    logic [7:0] q0;
    text_mode = 1;
    for (int i = 0; i < 12; i++) begin
      name_data = 8'hC3;
      slot_en = 1; @(posedge clk); @(negedge clk); slot_en = 0;
    end
    q0 = name_q;
    chk(q0 == 8'hC3, "R9 latch before hold", q0, 8'hC3);
    for (int i = 0; i < 6; i++) begin
      name_data = 8'(i * 17 + 1);
      @(posedge clk); @(negedge clk);
      chk(slot == 12, "R11 slot held", slot, 12);
      chk(acc_kind == 2 && pix_kind == 2, "R11 kinds held", {acc_kind, pix_kind}, 10);
      chk(name_q == q0, "R11 name_q held", name_q, q0);
      chk(line_adv == 0, "R11 no strobe", line_adv, 0);
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_line(1, 4'h0, 8'd0);
    t_line(1, 4'h7, 8'd37);
    t_line(1, 4'hF, 8'd191);
    t_line(0, 4'h5, 8'd77);
    t_line(0, 4'hA, 8'd255);
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule